// File: doc/BRIEF.md
# Command-Controlled Up/Down Timer

This block is a periodic timer/counter run by a small control register that software reaches through two write views. A write through the set view turns on every control bit written as 1. A write through the clear view turns off every control bit written as 1. Bits written as 0 are left alone in both views, so software never needs a read-modify-write. Both views act on the same state, and that state can be read back at any time.

The control state has three parts: a 3-bit command field, a one-shot enable and a count-direction bit. The command field holds a request until the next prescaler tick, carries it out on that tick and then clears itself. The commands are restart, stop, forced buffer update, count snapshot and a one-shot DMA trigger. The counter moves only on prescaler ticks while it is running. It wraps at a period value (TOP) and reports each wrap with a single-cycle pulse.

Top module: `cmd_timer`

## Requirements
- R1: After synchronous reset, `count` is 0, `running` is 0, `rd_data` is 0, `count_snap` is 0, and every pulse output is 0.
- R2: A written command has no effect on `count`, `running` or any pulse output until a cycle in which `tick` is high, and it reads back unchanged in `rd_data[2:0]` until then. With `tick` low, `count` and `running` hold.
- R3: The command field reads back as 0 in the cycle after a tick that carries it out, when no write happens in that cycle. Codes 6 and 7 are cleared the same way and have no other effect.
- R4: Control layout: `[2:0]` is the command, `[3]` is one-shot and `[4]` is direction. A write through the set view (`wr_clr`=0) sets bits 3 and 4 where the data is 1 and leaves them unchanged where it is 0. It loads a nonzero command value, and a zero command value leaves the command field as it was.
- R5: A write through the clear view (`wr_clr`=1) clears every control bit whose data bit is 1, including command bits. A command cleared this way does nothing on the next tick.
- R6: Command 1 (restart) on a tick loads `count` with 0 when direction is 0, or with `top` when direction is 1, and sets `running`.
- R7: Command 2 (stop) on a tick clears `running`, and `count` then holds through later ticks.
- R8: With direction 0 and `running` high, each tick adds 1 to `count`. On the tick where `count` equals `top`, `count` becomes 0 and `ovf` pulses for one cycle.
- R9: With direction 1 and `running` high, each tick subtracts 1 from `count`. On the tick where `count` is 0, `count` becomes `top` and `unf` pulses for one cycle.
- R10: With one-shot at 1, `running` clears on the same tick that wraps the counter. With one-shot at 0, counting continues after a wrap.
- R11: Command 3 (update) produces a single-cycle `upd_pulse` on the executing tick, and counting continues normally.
- R12: Command 4 (snapshot) loads `count_snap` with the value `count` had when the executing tick was sampled.
- R13: Command 5 produces a single-cycle `dma_trig` pulse on the executing tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Control write strobe |
| wr_clr | input | 1 | 1 selects the clear view, 0 selects the set view |
| wr_data | input | 5 | Control write data |
| tick | input | 1 | Prescaled counting tick |
| top | input | CW (8) | Period value |
| rd_data | output | 5 | Control state readback |
| count | output | CW (8) | Counter value |
| count_snap | output | CW (8) | Count captured by the snapshot command |
| running | output | 1 | Counter is active |
| ovf | output | 1 | Up-count wrap pulse |
| unf | output | 1 | Down-count wrap pulse |
| upd_pulse | output | 1 | Forced update pulse |
| dma_trig | output | 1 | One-shot DMA trigger pulse |

## Verification
A corrupted control register shows at once on `rd_data`, in the cycle after the write. A command field that fails to self-clear shows on the cycle after the executing tick. A wrong counter step or a wrong wrap point shows on `count` one cycle after the offending tick, and an error in the one-shot or stop logic shows on `running` at that same edge. Checks are placed one cycle after each tick edge, so a fault is caught within one tick of its cause, before later counting can hide it.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    localparam int CTRL_W     = 5;
    localparam int CMD_W      = 3;
    localparam int ONESHOT_IX = 3;
    localparam int DIR_IX     = 4;

    typedef enum logic [CMD_W-1:0] {
        CMD_IDLE      = 3'd0,
        CMD_RESTART   = 3'd1,
        CMD_HALT      = 3'd2,
        CMD_FORCE_UPD = 3'd3,
        CMD_SNAPSHOT  = 3'd4,
        CMD_DMA_KICK  = 3'd5
    } tmr_cmd_e;

    typedef struct packed {
        logic             dir;
        logic             oneshot;
        logic [CMD_W-1:0] cmd;
    } tmr_ctrl_t;

    typedef struct packed {
        logic restart;
        logic halt;
        logic upd;
        logic snap;
        logic dma;
    } tmr_strobe_t;

    function automatic logic [CTRL_W-1:0] ctrl_to_bus(tmr_ctrl_t c);
        logic [CTRL_W-1:0] v;
        v = '0;
        v[CMD_W-1:0]  = c.cmd;
        v[ONESHOT_IX] = c.oneshot;
        v[DIR_IX]     = c.dir;
        return v;
    endfunction

endpackage

// File: rtl/tmr_ctrl_reg.sv
module tmr_ctrl_reg
    import tmr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              wr_clr,
    input  logic [CTRL_W-1:0] wr_data,
    input  logic              exec,
    output tmr_ctrl_t         ctrl
);

    tmr_ctrl_t ctrl_nx;

    always_comb begin
        ctrl_nx = ctrl;
        // a tick consumes whatever command is pending
        if (exec) ctrl_nx.cmd = '0;
        if (wr_en) begin
            if (wr_clr) begin
                ctrl_nx.cmd     = ctrl_nx.cmd & ~wr_data[CMD_W-1:0];
                ctrl_nx.oneshot = ctrl_nx.oneshot & ~wr_data[ONESHOT_IX];
                ctrl_nx.dir     = ctrl_nx.dir & ~wr_data[DIR_IX];
            end else begin
                if (wr_data[CMD_W-1:0] != '0) ctrl_nx.cmd = wr_data[CMD_W-1:0];
                ctrl_nx.oneshot = ctrl_nx.oneshot | wr_data[ONESHOT_IX];
                ctrl_nx.dir     = ctrl_nx.dir | wr_data[DIR_IX];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) ctrl <= '0;
        else     ctrl <= ctrl_nx;
    end

    // R4: a set-view write never drops the direction or one-shot bit
    assert_set_keeps_bits_R4: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !wr_clr) |=> (ctrl.dir >= $past(ctrl.dir)) && (ctrl.oneshot >= $past(ctrl.oneshot)));

    // R5: a clear-view write never raises a bit
    assert_clr_no_raise_R5: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_clr && !exec) |=> (ctrl.dir <= $past(ctrl.dir)) && (ctrl.oneshot <= $past(ctrl.oneshot)));

endmodule

// File: rtl/tmr_cmd_decode.sv
module tmr_cmd_decode
    import tmr_pkg::*;
(
    input  logic [CMD_W-1:0] cmd,
    input  logic             fire,
    output tmr_strobe_t      strobe
);

    always_comb begin
        strobe = '0;
        if (fire) begin
            case (cmd)
                CMD_RESTART:   strobe.restart = 1'b1;
                CMD_HALT:      strobe.halt    = 1'b1;
                CMD_FORCE_UPD: strobe.upd     = 1'b1;
                CMD_SNAPSHOT:  strobe.snap    = 1'b1;
                CMD_DMA_KICK:  strobe.dma     = 1'b1;
                default:       strobe         = '0;
            endcase
        end
    end

    // at most one action per tick
    always_comb begin
        assert ($onehot0(strobe));
    end

endmodule

// File: rtl/tmr_counter.sv
module tmr_counter
    import tmr_pkg::*;
#(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          tick,
    input  logic [CW-1:0] top,
    input  logic          dir,
    input  logic          oneshot,
    input  tmr_strobe_t   strobe,
    output logic [CW-1:0] count,
    output logic [CW-1:0] count_snap,
    output logic          running,
    output logic          ovf,
    output logic          unf,
    output logic          upd_pulse,
    output logic          dma_trig
);

    localparam logic [CW-1:0] ZERO = '0;

    logic at_top;
    logic at_bot;

    assign at_top = (count >= top);
    assign at_bot = (count == ZERO);

    always_ff @(posedge clk) begin
        if (rst) begin
            count      <= '0;
            count_snap <= '0;
            running    <= 1'b0;
            ovf        <= 1'b0;
            unf        <= 1'b0;
            upd_pulse  <= 1'b0;
            dma_trig   <= 1'b0;
        end else begin
            ovf       <= 1'b0;
            unf       <= 1'b0;
            upd_pulse <= 1'b0;
            dma_trig  <= 1'b0;
            if (tick) begin
                upd_pulse <= strobe.upd;
                dma_trig  <= strobe.dma;
                if (strobe.snap) count_snap <= count;
                if (strobe.restart) begin
                    count   <= dir ? top : ZERO;
                    running <= 1'b1;
                end else if (strobe.halt) begin
                    running <= 1'b0;
                end else if (running) begin
                    if (!dir) begin
                        if (at_top) begin
                            count <= ZERO;
                            ovf   <= 1'b1;
                            if (oneshot) running <= 1'b0;
                        end else begin
                            count <= count + 1'b1;
                        end
                    end else begin
                        if (at_bot) begin
                            count <= top;
                            unf   <= 1'b1;
                            if (oneshot) running <= 1'b0;
                        end else begin
                            count <= count - 1'b1;
                        end
                    end
                end
            end
        end
    end

    assert_hold_no_tick_R2: assert property (@(posedge clk) disable iff (rst)
        !tick |=> $stable(count) && $stable(running));

    assert_ovf_lands_zero_R8: assert property (@(posedge clk) disable iff (rst)
        ovf |-> count == ZERO);

    assert_unf_lands_top_R9: assert property (@(posedge clk) disable iff (rst)
        unf |-> count == $past(top));

    assert_wrap_exclusive_R8: assert property (@(posedge clk) disable iff (rst)
        $onehot0({ovf, unf}));

    assert_oneshot_halts_R10: assert property (@(posedge clk) disable iff (rst)
        ((ovf || unf) && $past(oneshot)) |-> !running);

    assert_pulse_needs_tick_R13: assert property (@(posedge clk) disable iff (rst)
        (dma_trig || upd_pulse) |-> $past(tick));

endmodule

// File: rtl/cmd_timer.sv
module cmd_timer
    import tmr_pkg::*;
#(
    parameter int CW = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              wr_clr,
    input  logic [CTRL_W-1:0] wr_data,
    input  logic              tick,
    input  logic [CW-1:0]     top,
    output logic [CTRL_W-1:0] rd_data,
    output logic [CW-1:0]     count,
    output logic [CW-1:0]     count_snap,
    output logic              running,
    output logic              ovf,
    output logic              unf,
    output logic              upd_pulse,
    output logic              dma_trig
);

    tmr_ctrl_t   ctrl;
    tmr_strobe_t strobe;

    tmr_ctrl_reg u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_clr  (wr_clr),
        .wr_data (wr_data),
        .exec    (tick),
        .ctrl    (ctrl)
    );

    tmr_cmd_decode u_dec (
        .cmd    (ctrl.cmd),
        .fire   (tick),
        .strobe (strobe)
    );

    tmr_counter #(.CW(CW)) u_cnt (
        .clk        (clk),
        .rst        (rst),
        .tick       (tick),
        .top        (top),
        .dir        (ctrl.dir),
        .oneshot    (ctrl.oneshot),
        .strobe     (strobe),
        .count      (count),
        .count_snap (count_snap),
        .running    (running),
        .ovf        (ovf),
        .unf        (unf),
        .upd_pulse  (upd_pulse),
        .dma_trig   (dma_trig)
    );

    assign rd_data = ctrl_to_bus(ctrl);

    assert_cmd_self_clear_R3: assert property (@(posedge clk) disable iff (rst)
        (tick && !wr_en) |=> rd_data[CMD_W-1:0] == '0);

endmodule

// File: tb/tb_cmd_timer.sv
module tb_cmd_timer;

    localparam int CW = 8;
    localparam logic [CW-1:0] TOPV = 8'd3;

    logic          clk = 1'b0;
    logic          rst;
    logic          wr_en, wr_clr;
    logic [4:0]    wr_data;
    logic          tick;
    logic [CW-1:0] top;
    logic [4:0]    rd_data;
    logic [CW-1:0] count, count_snap;
    logic          running, ovf, unf, upd_pulse, dma_trig;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    cmd_timer #(.CW(CW)) dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_clr(wr_clr), .wr_data(wr_data),
        .tick(tick), .top(top), .rd_data(rd_data), .count(count),
        .count_snap(count_snap), .running(running), .ovf(ovf), .unf(unf),
        .upd_pulse(upd_pulse), .dma_trig(dma_trig)
    );

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic clr, input logic [4:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_clr = clr; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0; wr_clr = 1'b0; wr_data = '0;
    endtask

    task automatic pulse_tick();
        @(negedge clk); tick = 1'b1;
        @(negedge clk); tick = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic t_reset();
        check("R1 count", count, 0);
        check("R1 running", running, 0);
        check("R1 rd_data", rd_data, 0);
        check("R1 snap", count_snap, 0);
        check("R1 pulses", {ovf, unf, upd_pulse, dma_trig}, 0);
    endtask

    task automatic t_pending_and_restart();
        wr(1'b0, 5'h01);
        idle(3);
        check("R2 cmd pending", rd_data, 5'h01);
        check("R2 running idle", running, 0);
        wr(1'b0, 5'h00);
        check("R4 zero cmd no effect", rd_data, 5'h01);
        pulse_tick();
        check("R6 running", running, 1);
        check("R6 count up", count, 0);
        check("R3 cmd cleared", rd_data, 0);
    endtask

    task automatic t_up_count();
        for (int i = 1; i <= 3; i++) begin
            pulse_tick();
            check("R8 step", count, i);
        end
        idle(2);
        check("R2 hold without tick", count, 3);
        pulse_tick();
        check("R8 wrap", count, 0);
        check("R8 ovf pulse", ovf, 1);
        idle(1);
        check("R8 ovf one cycle", ovf, 0);
        check("R10 continuous", running, 1);
    endtask

    task automatic t_stop();
        pulse_tick();
        check("R8 step after wrap", count, 1);
        wr(1'b0, 5'h02);
        pulse_tick();
        check("R7 stopped", running, 0);
        pulse_tick();
        check("R7 count holds", count, 1);
    endtask

    task automatic t_down_oneshot();
        wr(1'b0, 5'h11);
        check("R4 dir set", rd_data, 5'h11);
        pulse_tick();
        check("R6 count down load", count, TOPV);
        check("R3 cmd cleared down", rd_data, 5'h10);
        for (int i = 2; i >= 0; i--) begin
            pulse_tick();
            check("R9 step", count, i);
        end
        pulse_tick();
        check("R9 wrap", count, TOPV);
        check("R9 unf pulse", unf, 1);
        check("R10 continuous down", running, 1);
        wr(1'b0, 5'h09);
        check("R4 oneshot set", rd_data, 5'h19);
        pulse_tick();
        for (int i = 0; i < 3; i++) pulse_tick();
        check("R9 at zero", count, 0);
        pulse_tick();
        check("R9 oneshot wrap", unf, 1);
        check("R10 oneshot stop", running, 0);
        pulse_tick();
        check("R10 stays stopped", count, TOPV);
    endtask

    task automatic t_clear_view();
        wr(1'b1, 5'h18);
        check("R5 bits cleared", rd_data, 0);
        wr(1'b0, 5'h03);
        wr(1'b1, 5'h07);
        check("R5 cmd cleared", rd_data, 0);
        pulse_tick();
        check("R5 cancelled cmd", upd_pulse, 0);
    endtask

    task automatic t_aux_cmds();
        wr(1'b0, 5'h03);
        pulse_tick();
        check("R11 upd pulse", upd_pulse, 1);
        idle(1);
        check("R11 upd one cycle", upd_pulse, 0);
        wr(1'b0, 5'h01);
        pulse_tick();
        pulse_tick();
        pulse_tick();
        wr(1'b0, 5'h04);
        pulse_tick();
        check("R12 snapshot", count_snap, 2);
        check("R12 counting continues", count, 3);
        wr(1'b0, 5'h05);
        pulse_tick();
        check("R13 dma pulse", dma_trig, 1);
        check("R8 wrap with dma", ovf, 1);
        idle(1);
        check("R13 dma one cycle", dma_trig, 0);
        wr(1'b0, 5'h06);
        check("R3 invalid readback", rd_data, 5'h06);
        pulse_tick();
        check("R3 invalid cleared", rd_data, 0);
        check("R3 invalid no effect", {running, count}, {1'b1, 8'd1});
        wr(1'b0, 5'h08);
        pulse_tick();
        pulse_tick();
        pulse_tick();
        check("R10 up oneshot ovf", ovf, 1);
        check("R10 up oneshot stop", running, 0);
    endtask

    initial begin
        rst = 1'b1; wr_en = 1'b0; wr_clr = 1'b0; wr_data = '0; tick = 1'b0; top = TOPV;
        idle(3);
        rst = 1'b0;
        idle(1);
        t_reset();
        t_pending_and_restart();
        t_up_count();
        t_stop();
        t_down_oneshot();
        t_clear_view();
        t_aux_cmds();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #200000;
        checks++;
        errors++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule